// File: doc/BRIEF.md
# Multi-Hit Channel Latch Register

This block records events on a bank of input channels. Each channel has two latches. The first latch catches the first rising edge on the channel. The second latch catches any later rising edge that arrives while the first is still set, so software can tell a single event from a pile-up. The channel inputs pass through a synchronizer whose depth is a parameter, and an edge detector turns each level change into a one-cycle hit.

Software reaches the latches through a small register bus. There are two read-only views, one for the first latches and one for the second latches, and reading a view clears that latch in every channel. A hit that lands in the same cycle as a clear is kept, so no event is lost.

A separate test channel is driven by a pushbutton. It has its own latch and three masks: one gates the test output pin, one removes the test latch from the combined OR output, and one removes it from the interrupt request. A control register sets the masks, clears the test latch, and shows the live pushbutton level. All read data is registered and appears on the cycle after the read strobe.

Top module: `hitlat_bank`

## Requirements
- R1: After reset every latch is clear, all three test masks are 0, `or_o`, `irq_o` and `test_out_o` are 0, and `bus_rdata_o` is 0.
- R2: The first rising edge on channel i sets bit i of the first-hit view (offset 0x16) and leaves bit i of the repeat-hit view (offset 0x18) at 0.
- R3: A rising edge on channel i while its first-hit bit is set sets bit i of the repeat-hit view. An input held high for many cycles counts as one hit.
- R4: A read of offset 0x16 returns the first-hit bits on `bus_rdata_o` in the cycle after the strobe and clears every first-hit bit. Repeat-hit bits are not changed.
- R5: A read of offset 0x18 returns the repeat-hit bits in the cycle after the strobe and clears every repeat-hit bit. First-hit bits are not changed.
- R6: A hit whose latch update lands in the same cycle as a clearing read is kept. The read returns the value held before that cycle. If the first-hit bit was already set, the hit also sets the repeat-hit bit.
- R7: Writes to offsets 0x16 and 0x18 have no effect. A read of any unmapped offset returns 0.
- R8: The control register at offset 0x1A uses these bits: bit 1 is the output mask, bit 2 is the OR mask and bit 3 is the interrupt mask, and all three are read/write. Bit 0 always reads 0. Bit 4 is read-only and shows the synchronized pushbutton level. Bits 15..5 read 0.
- R9: A rising edge of the pushbutton sets the test latch. Writing 1 to bit 0 of offset 0x1A clears it, unless a button edge lands in the same cycle, in which case the latch stays set.
- R10: `test_out_o` is 1 exactly when the test latch is set and the output mask is 0.
- R11: `or_o` is 1 when any first-hit bit is set, or when the test latch is set and the OR mask is 0.
- R12: `irq_o` is 1 when any first-hit bit is set, or when the test latch is set and the interrupt mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NCH | Channel event inputs (asynchronous levels) |
| btn_i | input | 1 | Test pushbutton level (asynchronous) |
| bus_addr_i | input | AW | Register byte offset |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data, valid the cycle after the read strobe |
| or_o | output | 1 | Combined OR of channel latches and the test latch |
| irq_o | output | 1 | Interrupt request |
| test_out_o | output | 1 | Gated test channel output |

## Verification
The bench times a channel hit so that its latch update lands in exactly the same cycle as a clearing read. A design in which the clear wins would drop that event, and a design that sets the repeat bit wrongly would report a false pile-up. The bench checks that each clearing read leaves the other view untouched, since a shared clear would silently wipe repeat history. It holds an input high for several cycles to catch a level-sensitive latch that counts many hits. It also walks each test mask on its own, so that a mask wired to the wrong output shows up, and it times a button edge to land on the clear write.

// File: rtl/hitlat_pkg.sv
package hitlat_pkg;

   // control register bit positions (the bus decodes these)
   localparam int CTL_CLR  = 0;
   localparam int CTL_MASK = 1;
   localparam int CTL_ORM  = 2;
   localparam int CTL_IRQM = 3;
   localparam int CTL_BTN  = 4;
   localparam int CTL_USED = CTL_BTN + 1;

   typedef struct packed {
      logic irq_mask;
      logic or_mask;
      logic out_mask;
   } test_cfg_t;

endpackage

// File: rtl/hitlat_sync.sv
module hitlat_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hitlat_chan.sv
module hitlat_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_first_i,
   input  logic clr_second_i,
   output logic first_o,
   output logic second_o
);

   logic prev_q;
   logic first_q;
   logic second_q;
   logic rise;

   assign rise = lvl_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         first_q  <= 1'b0;
         second_q <= 1'b0;
      end else begin
         prev_q   <= lvl_i;
         // a hit always overrides a clear arriving in the same cycle
         first_q  <= rise | (first_q & ~clr_first_i);
         second_q <= (rise & first_q) | (second_q & ~clr_second_i);
      end
   end

   assign first_o  = first_q;
   assign second_o = second_q;

   a_r2_edge_sets_first: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> first_o);

   a_r3_repeat_sets_second: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && first_o) |=> second_o);

   a_r3_level_no_rehit: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_q && lvl_i && !second_o) |=> !second_o);

   a_r4_first_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_first_i && !rise) |=> !first_o);

   a_r5_second_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_second_i && !(rise && first_o)) |=> !second_o);

   a_r5_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_second_i && !clr_first_i && first_o) |=> first_o);

   a_r6_hit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && clr_first_i) |=> first_o);

endmodule

// File: rtl/hitlat_test.sv
module hitlat_test
   import hitlat_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            btn_i,
   input  logic            ctl_wr_i,
   input  logic [CTL_IRQM:CTL_CLR] ctl_wdata_i,
   output logic            latch_o,
   output test_cfg_t       cfg_o,
   output logic            out_o,
   output logic            or_term_o,
   output logic            irq_term_o
);

   logic      prev_q;
   logic      latch_q;
   test_cfg_t cfg_q;
   logic      rise;
   logic      clr;

   assign rise = btn_i & ~prev_q;
   assign clr  = ctl_wr_i & ctl_wdata_i[CTL_CLR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
         cfg_q   <= '0;
      end else begin
         prev_q  <= btn_i;
         latch_q <= rise | (latch_q & ~clr);
         if (ctl_wr_i) begin
            cfg_q.out_mask <= ctl_wdata_i[CTL_MASK];
            cfg_q.or_mask  <= ctl_wdata_i[CTL_ORM];
            cfg_q.irq_mask <= ctl_wdata_i[CTL_IRQM];
         end
      end
   end

   assign latch_o    = latch_q;
   assign cfg_o      = cfg_q;
   assign out_o      = latch_q & ~cfg_q.out_mask;
   assign or_term_o  = latch_q & ~cfg_q.or_mask;
   assign irq_term_o = latch_q & ~cfg_q.irq_mask;

   a_r9_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !rise) |=> !latch_o);

   a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> latch_o);

   a_r8_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr_i |=> $stable(cfg_o));

   a_r10_mask_blocks_out: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_o.out_mask |-> !out_o);

endmodule

// File: rtl/hitlat_bank.sv
module hitlat_bank
   import hitlat_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter logic [AW-1:0] ADDR_FIRST  = 'h16,
   parameter logic [AW-1:0] ADDR_REPEAT = 'h18,
   parameter logic [AW-1:0] ADDR_TEST   = 'h1A
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] hit_i,
   input  logic           btn_i,
   input  logic [AW-1:0]  bus_addr_i,
   input  logic           bus_rd_i,
   input  logic           bus_wr_i,
   input  logic [DW-1:0]  bus_wdata_i,
   output logic [DW-1:0]  bus_rdata_o,
   output logic           or_o,
   output logic           irq_o,
   output logic           test_out_o
);

   localparam int SW = NCH + 1;

   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         initial $fatal(1, "hitlat_bank: NCH must be 1..DW");
      end
      if (DW < CTL_USED) begin : g_bad_dw
         initial $fatal(1, "hitlat_bank: DW too narrow for control register");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         initial $fatal(1, "hitlat_bank: SYNC_STAGES must be 0..4");
      end
      if (ADDR_FIRST == ADDR_REPEAT || ADDR_FIRST == ADDR_TEST ||
          ADDR_REPEAT == ADDR_TEST) begin : g_bad_map
         initial $fatal(1, "hitlat_bank: register offsets overlap");
      end
   endgenerate

   logic [SW-1:0]  raw_in;
   logic [SW-1:0]  sync_in;
   logic [NCH-1:0] hit_s;
   logic           btn_s;

   assign raw_in = {btn_i, hit_i};

   hitlat_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_in)
   );

   assign hit_s = sync_in[NCH-1:0];
   assign btn_s = sync_in[NCH];

   // register decode
   logic rd_first, rd_repeat, rd_test, wr_test;
   assign rd_first  = bus_rd_i && (bus_addr_i == ADDR_FIRST);
   assign rd_repeat = bus_rd_i && (bus_addr_i == ADDR_REPEAT);
   assign rd_test   = bus_rd_i && (bus_addr_i == ADDR_TEST);
   assign wr_test   = bus_wr_i && (bus_addr_i == ADDR_TEST);

   logic [NCH-1:0] first_vec;
   logic [NCH-1:0] second_vec;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chan
         hitlat_chan u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .lvl_i        (hit_s[c]),
            .clr_first_i  (rd_first),
            .clr_second_i (rd_repeat),
            .first_o      (first_vec[c]),
            .second_o     (second_vec[c])
         );
      end
   endgenerate

   logic      test_latch;
   test_cfg_t test_cfg;
   logic      test_or_term;
   logic      test_irq_term;

   hitlat_test u_test (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_i       (btn_s),
      .ctl_wr_i    (wr_test),
      .ctl_wdata_i (bus_wdata_i[CTL_IRQM:CTL_CLR]),
      .latch_o     (test_latch),
      .cfg_o       (test_cfg),
      .out_o       (test_out_o),
      .or_term_o   (test_or_term),
      .irq_term_o  (test_irq_term)
   );

   // write data bits above the control field carry no meaning
   logic wdata_unused;
   assign wdata_unused = ^bus_wdata_i[DW-1:CTL_IRQM+1];

   // read words, zero-extended to the bus width
   logic [DW-1:0] first_word, second_word, ctl_word, rd_word;

   always_comb begin
      first_word             = '0;
      first_word[NCH-1:0]    = first_vec;
      second_word            = '0;
      second_word[NCH-1:0]   = second_vec;
      ctl_word               = '0;
      ctl_word[CTL_MASK]     = test_cfg.out_mask;
      ctl_word[CTL_ORM]      = test_cfg.or_mask;
      ctl_word[CTL_IRQM]     = test_cfg.irq_mask;
      ctl_word[CTL_BTN]      = btn_s;
      if (rd_first)       rd_word = first_word;
      else if (rd_repeat) rd_word = second_word;
      else if (rd_test)   rd_word = ctl_word;
      else                rd_word = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_word;
   end

   assign or_o  = (|first_vec) | test_or_term;
   assign irq_o = (|first_vec) | test_irq_term;

   a_r4_read_gives_prior: assert property (@(posedge clk) disable iff (!rst_n)
      rd_first |=> (bus_rdata_o == $past(first_word)));

   a_r5_read_gives_prior: assert property (@(posedge clk) disable iff (!rst_n)
      rd_repeat |=> (bus_rdata_o == $past(second_word)));

   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && !rd_first && !rd_repeat && !rd_test) |=> (bus_rdata_o == '0));

   a_r8_ctl_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_test |=> !bus_rdata_o[CTL_CLR]);

   a_r11_or_covers_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
      (|first_vec) |-> (or_o && irq_o));

   a_r12_irq_masked_test: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vec == '0 && test_cfg.irq_mask) |-> !irq_o);

   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!or_o && !irq_o && !test_out_o && bus_rdata_o == '0));

endmodule

// File: tb/hitlat_bank_bench.sv
module hitlat_bank_bench;

   localparam int CLK_NS = 10;
   localparam int NCH    = 16;
   localparam int SS     = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] hit_i = '0;
   logic           btn_i = 1'b0;
   logic [7:0]     bus_addr_i = '0;
   logic           bus_rd_i = 1'b0;
   logic           bus_wr_i = 1'b0;
   logic [15:0]    bus_wdata_i = '0;
   logic [15:0]    bus_rdata_o;
   logic           or_o, irq_o, test_out_o;

   int vectors = 0;
   int miscompares = 0;
   logic done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   hitlat_bank #(.NCH(NCH), .SYNC_STAGES(SS)) u_hitlat_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit_i),
      .btn_i       (btn_i),
      .bus_addr_i  (bus_addr_i),
      .bus_rd_i    (bus_rd_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .or_o        (or_o),
      .irq_o       (irq_o),
      .test_out_o  (test_out_o)
   );

   // scoreboard
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= bus_rd_i;

   always @(negedge clk) begin
      if (rd_seen) begin
         vectors++;
         if (exp_q.size() == 0) begin
            miscompares++;
            $display("FAIL read with no expectation: actual %h", bus_rdata_o);
         end else begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (bus_rdata_o !== e) begin
               miscompares++;
               $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata_o, e);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [15:0] e, input string tag);
      bus_addr_i = a;
      bus_rd_i   = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      tick();
      bus_rd_i   = 1'b0;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      bus_addr_i  = a;
      bus_wdata_i = d;
      bus_wr_i    = 1'b1;
      tick();
      bus_wr_i    = 1'b0;
   endtask

   task automatic pulse(input logic [NCH-1:0] m);
      hit_i = hit_i | m;
      tick();
      hit_i = hit_i & ~m;
      repeat (SS + 2) tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (4) tick();
      chk("R1 or_o in reset", or_o, 1'b0);
      chk("R1 irq_o in reset", irq_o, 1'b0);
      chk("R1 test_out_o in reset", test_out_o, 1'b0);
      rst_n = 1'b1;
      tick();
      bus_read(8'h16, 16'h0000, "R1 first view");
      bus_read(8'h18, 16'h0000, "R1 repeat view");
      bus_read(8'h1A, 16'h0000, "R1 control");

      // R2: single hit
      pulse(16'h0008);
      chk("R11 or from channel", or_o, 1'b1);
      chk("R12 irq from channel", irq_o, 1'b1);
      bus_read(8'h18, 16'h0000, "R2 no repeat after one hit");
      bus_read(8'h16, 16'h0008, "R2 first bit 3");
      bus_read(8'h16, 16'h0000, "R4 first cleared");
      chk("R11 or idle", or_o, 1'b0);

      // R3: repeats and held level
      pulse(16'h0020);
      pulse(16'h0020);
      pulse(16'h0200);
      hit_i[0] = 1'b1;
      repeat (6) tick();
      hit_i[0] = 1'b0;
      repeat (SS + 2) tick();
      bus_read(8'h18, 16'h0020, "R3 repeat bit 5 only");
      bus_read(8'h18, 16'h0000, "R5 repeat cleared");
      bus_read(8'h16, 16'h0221, "R5 first untouched");

      // R4: first clear keeps repeats
      pulse(16'h0080);
      pulse(16'h0080);
      bus_read(8'h16, 16'h0080, "R4 first bit 7");
      bus_read(8'h18, 16'h0080, "R4 repeat untouched");
      bus_read(8'h16, 16'h0000, "R4 first stays clear");

      // R7: read-only writes, unmapped read
      pulse(16'h0002);
      pulse(16'h0002);
      pulse(16'h8001);
      bus_write(8'h16, 16'hFFFF);
      bus_write(8'h18, 16'hFFFF);
      bus_write(8'h16, 16'h0000);
      bus_read(8'h10, 16'h0000, "R7 unmapped");
      bus_read(8'h16, 16'h8003, "R7 first after writes");
      bus_read(8'h18, 16'h0002, "R7 repeat after writes");

      // R6: hit lands on clearing read
      pulse(16'h0004);
      hit_i = 16'h0004;
      tick();
      hit_i = '0;
      repeat (SS - 1) tick();
      bus_read(8'h16, 16'h0004, "R6 read returns prior");
      repeat (SS + 2) tick();
      bus_read(8'h16, 16'h0004, "R6 hit survived clear");
      bus_read(8'h18, 16'h0004, "R6 race set repeat");
      bus_read(8'h16, 16'h0000, "R6 then clear");
      chk("R11 all clear", or_o, 1'b0);

      // test channel
      btn_i = 1'b1;
      repeat (SS + 2) tick();
      bus_read(8'h1A, 16'h0010, "R8 button level");
      chk("R10 test out", test_out_o, 1'b1);
      chk("R11 or from test", or_o, 1'b1);
      chk("R12 irq from test", irq_o, 1'b1);
      btn_i = 1'b0;
      repeat (SS + 2) tick();
      bus_write(8'h1A, 16'h0002);
      chk("R10 out masked", test_out_o, 1'b0);
      chk("R10 or unaffected by out mask", or_o, 1'b1);
      bus_write(8'h1A, 16'h0004);
      chk("R11 or masked", or_o, 1'b0);
      chk("R11 irq unaffected by or mask", irq_o, 1'b1);
      chk("R11 out unaffected by or mask", test_out_o, 1'b1);
      bus_write(8'h1A, 16'h0008);
      chk("R12 irq masked", irq_o, 1'b0);
      chk("R12 or unaffected by irq mask", or_o, 1'b1);
      bus_write(8'h1A, 16'h000E);
      bus_read(8'h1A, 16'h000E, "R8 masks read back");
      pulse(16'h0010);
      chk("R11 channel or with test masked", or_o, 1'b1);
      chk("R12 channel irq with test masked", irq_o, 1'b1);
      bus_read(8'h16, 16'h0010, "R4 clear channel 4");
      chk("R11 or off all masked", or_o, 1'b0);
      bus_write(8'h1A, 16'hFFFF);
      bus_read(8'h1A, 16'h000E, "R8 clear bit and high bits read 0");
      bus_write(8'h1A, 16'h0000);
      chk("R9 latch cleared", test_out_o, 1'b0);
      chk("R9 or after clear", or_o, 1'b0);

      // R9: button edge lands on clear write
      btn_i = 1'b1;
      tick();
      repeat (SS - 1) tick();
      bus_write(8'h1A, 16'h0001);
      tick();
      chk("R9 edge beats clear", test_out_o, 1'b1);
      btn_i = 1'b0;
      repeat (SS + 2) tick();
      bus_write(8'h1A, 16'h0001);
      chk("R9 clear write", test_out_o, 1'b0);
      bus_read(8'h1A, 16'h0000, "R8 final control");

      repeat (3) tick();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule